// File: doc/BRIEF.md
# Multimaster I2C Bus Occupancy Monitor

This block listens to the data and clock lines of an I2C bus that several masters share. It does not drive the lines. It keeps two flags: a busy flag, and a sticky flag that records that the bus became free. From these it decides whether the local master may begin a transfer. The difficulty comes after an enable or a soft reset. At that point the busy flag is seeded from a single sample of the two lines. While another master is part-way through a transfer, that sample can read "free" even though the bus is in use. A transfer launched on that wrong value can stall the local controller or corrupt the other master's data.

For this reason the block treats the busy flag as untrusted until a qualification step ends. Qualification ends at once if the monitor sees any bus condition (START, STOP, or data held low while the clock is high). It also ends if both lines stay high for an unbroken idle window. If neither happens within an overall time limit, the block reports a timeout and withholds the grant. A request is granted only after qualification has ended and only while the bus is not busy.

The qualification controller has four states:
- `QS_OFF`: the block is disabled.
- `QS_QUAL`: the busy flag is not yet trusted.
- `QS_READY`: the busy flag is trusted.
- `QS_FAIL`: the time limit expired.

Its transitions are:
- OFF to QUAL when enable rises.
- QUAL to READY on a bus condition or when the idle window completes.
- QUAL to FAIL when the time limit expires.
- Any state to QUAL on a soft reset while enabled.
- Any state to OFF when enable is low.

With the bypass parameter set, every entry into QUAL goes straight to READY instead.

Top module: `i2c_busy_monitor`

## Requirements
- R1: After the asynchronous reset, all five outputs are low.
- R2: On the first cycle that enable is high, the block seeds busy from the filtered lines and clears bus_free. Busy is set only for data low with clock high. Data/clock combinations 0/0, 1/0 and 1/1 give busy low. The seeded value appears on the output one clock later. While enable is low, busy, bus_free and qual_done are held low.
- R3: While enabled, busy is set in two cases: data falls while clock stays high (START), or data is low while clock is high.
- R4: A rise of data while clock stays high (STOP) clears busy and sets bus_free. bus_free then stays set until a cycle with bf_clr high, or until a reseed.
- R5: busy and bus_free follow the bus conditions in every qualification state, including QS_FAIL. They do so whether or not a transfer is requested.
- R6: A soft reset while enabled reseeds busy, clears bus_free, clears qual_done and qual_timeout, and restarts qualification.
- R7: In QS_QUAL, any START, STOP or data-low-with-clock-high condition moves the block to QS_READY on the next edge. qual_done then rises.
- R8: In QS_QUAL, IDLE_CYC consecutive cycles with both filtered lines high end qualification. A low level on either line restarts the count.
- R9: If qualification has not ended within TMO_CYC cycles, qual_timeout rises and stays high until a soft reset or until enable drops. No grant is given in this state.
- R10: xfer_grant is high only when xfer_req is high, qual_done is high and busy is low.
- R11: Each line passes through a SYNC_STAGES-flop synchroniser and a filter. The filter accepts a new level only after it has been stable for FILT_LEN cycles, so a pulse of 2 input cycles or fewer (with FILT_LEN=3) has no effect on busy or bus_free.
- R12: With BYPASS_QUAL=1, qual_done is high one clock after enable rises or after a soft reset, whatever the line state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset pulse; reseeds flags and restarts qualification |
| enable | input | 1 | Block enable; its rising edge seeds the busy flag |
| sda_raw | input | 1 | Unsynchronised data line |
| scl_raw | input | 1 | Unsynchronised clock line |
| xfer_req | input | 1 | Local master asks to start a transfer |
| bf_clr | input | 1 | Write-one-to-clear strobe for bus_free |
| busy | output | 1 | Bus occupied by some master |
| bus_free | output | 1 | Sticky: a STOP has been seen |
| qual_done | output | 1 | Busy flag is trusted |
| xfer_grant | output | 1 | Local transfer may start |
| qual_timeout | output | 1 | Qualification failed within the time limit |

## Verification
The hardest case to reach is the idle window being restarted without ending qualification. Pulling data low while the clock is high counts as a bus condition and finishes qualification at once. So the stimulus instead drops only the clock line for a few cycles after the window is partly filled, with data kept high. It then checks that qual_done is still low at a point the original window would already have passed, and high once a fresh full window has elapsed. The timeout is reached by holding the clock low from enable onwards, so that neither an event nor an idle window can occur. Bus conditions are then driven while in that failed state, to show that the flags keep tracking the bus.

// File: rtl/busmon_pkg.sv
package busmon_pkg;

    typedef enum logic [1:0] {
        QS_OFF   = 2'd0,
        QS_QUAL  = 2'd1,
        QS_READY = 2'd2,
        QS_FAIL  = 2'd3
    } qual_state_t;

    typedef struct packed {
        logic start;   // data falls, clock high
        logic stop;    // data rises, clock high
        logic hold;    // data low while clock high
    } bus_evt_t;

    localparam int NUM_LINES = 2;
    localparam int LINE_SDA  = 0;
    localparam int LINE_SCL  = 1;

endpackage

// File: rtl/bm_line_filter.sv
module bm_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic filt
);
    localparam int CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(FILT_LEN - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          stab_cnt;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    // idle bus level is high, so the chain resets to ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt     <= 1'b1;
            stab_cnt <= '0;
        end else if (synced == filt) begin
            stab_cnt <= '0;
        end else if (stab_cnt == CNT_LAST) begin
            filt     <= synced;
            stab_cnt <= '0;
        end else begin
            stab_cnt <= stab_cnt + CW'(1);
        end
    end

endmodule

// File: rtl/bm_cond_detect.sv
module bm_cond_detect
    import busmon_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sda,
    input  logic     scl,
    output bus_evt_t evt
);
    logic sda_p;
    logic scl_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_p <= 1'b1;
            scl_p <= 1'b1;
        end else begin
            sda_p <= sda;
            scl_p <= scl;
        end
    end

    always_comb begin
        evt.start = sda_p && !sda && scl_p && scl;
        evt.stop  = !sda_p && sda && scl_p && scl;
        evt.hold  = !sda && scl;
    end

endmodule

// File: rtl/bm_flag_track.sv
module bm_flag_track
    import busmon_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     enable,
    input  logic     load,
    input  logic     sda,
    input  logic     scl,
    input  bus_evt_t evt,
    input  logic     bf_clr,
    output logic     busy,
    output logic     bus_free
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            bus_free <= 1'b0;
        end else if (!enable) begin
            busy     <= 1'b0;
            bus_free <= 1'b0;
        end else if (load) begin
            busy     <= !sda && scl;
            bus_free <= 1'b0;
        end else begin
            if (evt.stop) begin
                busy <= 1'b0;
            end else if (evt.start || evt.hold) begin
                busy <= 1'b1;
            end
            if (evt.stop) begin
                bus_free <= 1'b1;
            end else if (bf_clr) begin
                bus_free <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/bm_qual_fsm.sv
module bm_qual_fsm
    import busmon_pkg::*;
#(
    parameter int IDLE_CYC    = 2_500_000,
    parameter int TMO_CYC     = 25_000_000,
    parameter bit BYPASS_QUAL = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        load,
    input  logic        lines_high,
    input  logic        evt_any,
    output logic        qual_done,
    output logic        qual_fail,
    output qual_state_t state
);
    localparam int IW = $clog2(IDLE_CYC + 1);
    localparam int TW = $clog2(TMO_CYC + 1);
    localparam logic [IW-1:0] IDLE_LAST = IW'(IDLE_CYC - 1);
    localparam logic [TW-1:0] TMO_LAST  = TW'(TMO_CYC - 1);
    localparam qual_state_t   ENTRY_ST  = BYPASS_QUAL ? QS_READY : QS_QUAL;

    qual_state_t    nxt;
    logic [IW-1:0]  idle_cnt;
    logic [TW-1:0]  tmo_cnt;
    logic           idle_hit;
    logic           tmo_hit;

    assign idle_hit = lines_high && (idle_cnt == IDLE_LAST);
    assign tmo_hit  = (tmo_cnt == TMO_LAST);

    // window and limit counters, live only while qualifying
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_cnt <= '0;
            tmo_cnt  <= '0;
        end else if (state != QS_QUAL || load) begin
            idle_cnt <= '0;
            tmo_cnt  <= '0;
        end else begin
            idle_cnt <= lines_high ? idle_cnt + IW'(1) : '0;
            tmo_cnt  <= tmo_cnt + TW'(1);
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= QS_OFF;
        end else begin
            state <= nxt;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            QS_OFF: begin
                if (enable) nxt = ENTRY_ST;
            end
            QS_QUAL: begin
                if (evt_any || idle_hit) begin
                    nxt = QS_READY;
                end else if (tmo_hit) begin
                    nxt = QS_FAIL;
                end
            end
            QS_READY: nxt = QS_READY;
            QS_FAIL:  nxt = QS_FAIL;
            default:  nxt = QS_OFF;
        endcase
        if (!enable) begin
            nxt = QS_OFF;
        end else if (load) begin
            nxt = ENTRY_ST;
        end
    end

    // state outputs
    always_comb begin
        qual_done = 1'b0;
        qual_fail = 1'b0;
        unique case (state)
            QS_READY: qual_done = 1'b1;
            QS_FAIL:  qual_fail = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/i2c_busy_monitor.sv
module i2c_busy_monitor
    import busmon_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3,
    parameter int IDLE_CYC    = 2_500_000,
    parameter int TMO_CYC     = 25_000_000,
    parameter bit BYPASS_QUAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic enable,
    input  logic sda_raw,
    input  logic scl_raw,
    input  logic xfer_req,
    input  logic bf_clr,
    output logic busy,
    output logic bus_free,
    output logic qual_done,
    output logic xfer_grant,
    output logic qual_timeout
);
    logic [NUM_LINES-1:0] line_raw;
    logic [NUM_LINES-1:0] line_f;
    logic                 sda_f;
    logic                 scl_f;
    logic                 en_q;
    logic                 load;
    bus_evt_t             evt;
    logic                 evt_start;
    logic                 evt_stop;
    logic                 evt_hold;
    qual_state_t          q_state;

    assign line_raw[LINE_SDA] = sda_raw;
    assign line_raw[LINE_SCL] = scl_raw;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        bm_line_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_LEN    (FILT_LEN)
        ) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (line_raw[g]),
            .filt (line_f[g])
        );
    end

    assign sda_f = line_f[LINE_SDA];
    assign scl_f = line_f[LINE_SCL];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= enable;
    end

    assign load = enable && (!en_q || soft_rst);

    bm_cond_detect u_det (
        .clk  (clk),
        .rst_n(rst_n),
        .sda  (sda_f),
        .scl  (scl_f),
        .evt  (evt)
    );

    assign evt_start = evt.start;
    assign evt_stop  = evt.stop;
    assign evt_hold  = evt.hold;

    bm_flag_track u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .load    (load),
        .sda     (sda_f),
        .scl     (scl_f),
        .evt     (evt),
        .bf_clr  (bf_clr),
        .busy    (busy),
        .bus_free(bus_free)
    );

    bm_qual_fsm #(
        .IDLE_CYC   (IDLE_CYC),
        .TMO_CYC    (TMO_CYC),
        .BYPASS_QUAL(BYPASS_QUAL)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .load      (load),
        .lines_high(sda_f && scl_f),
        .evt_any   (evt_start || evt_stop || evt_hold),
        .qual_done (qual_done),
        .qual_fail (qual_timeout),
        .state     (q_state)
    );

    assign xfer_grant = xfer_req && qual_done && !busy;

endmodule

// File: rtl/i2c_busy_monitor_chk.sv
module i2c_busy_monitor_chk #(
    parameter bit BYPASS_QUAL = 1'b0
) (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic soft_rst,
    input logic bf_clr,
    input logic load,
    input logic evt_stop,
    input logic evt_hold,
    input logic busy,
    input logic bus_free,
    input logic qual_done,
    input logic qual_timeout
);
    a_r4_stop_frees: assert property (@(posedge clk) disable iff (!rst_n)
        enable && !load && evt_stop |=> bus_free && !busy);

    a_r3_hold_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        enable && !load && evt_hold |=> busy);

    a_r4_free_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        enable && !load && bus_free && !bf_clr |=> bus_free);

    a_r6_softrst_requal: assert property (@(posedge clk) disable iff (!rst_n)
        (BYPASS_QUAL == 1'b0) && enable && soft_rst |=> !qual_done && !qual_timeout);

    a_r9_fail_holds: assert property (@(posedge clk) disable iff (!rst_n)
        enable && qual_timeout && !soft_rst |=> qual_timeout);

    a_r2_off_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !busy && !bus_free && !qual_done);

endmodule

bind i2c_busy_monitor i2c_busy_monitor_chk #(.BYPASS_QUAL(BYPASS_QUAL)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .soft_rst    (soft_rst),
    .bf_clr      (bf_clr),
    .load        (load),
    .evt_stop    (evt_stop),
    .evt_hold    (evt_hold),
    .busy        (busy),
    .bus_free    (bus_free),
    .qual_done   (qual_done),
    .qual_timeout(qual_timeout)
);

// File: tb/test_i2c_busy_monitor.sv
`timescale 1ns/1ps
module test_i2c_busy_monitor;

    // observed vector: [4] busy [3] bus_free [2] qual_done [1] grant [0] timeout
    typedef struct {
        string      tag;
        bit         byp;
        logic [4:0] mask;
        logic [4:0] exp;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 1'b0, enable = 1'b0, sda = 1'b1, scl = 1'b1;
    logic xfer_req = 1'b0, bf_clr = 1'b0;
    logic busy, bus_free, qual_done, xfer_grant, qual_timeout;
    logic busy_b, free_b, done_b, grant_b, tmo_b;

    exp_t sb[$];
    int   n_chk = 0;
    int   n_err = 0;
    bit   finished = 1'b0;

    always #2 clk = ~clk;

    i2c_busy_monitor #(.IDLE_CYC(40), .TMO_CYC(300)) i_i2c_busy_monitor (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .enable(enable),
        .sda_raw(sda), .scl_raw(scl), .xfer_req(xfer_req), .bf_clr(bf_clr),
        .busy(busy), .bus_free(bus_free), .qual_done(qual_done),
        .xfer_grant(xfer_grant), .qual_timeout(qual_timeout));

    i2c_busy_monitor #(.IDLE_CYC(40), .TMO_CYC(300), .BYPASS_QUAL(1'b1)) i_i2c_busy_monitor_byp (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .enable(enable),
        .sda_raw(sda), .scl_raw(scl), .xfer_req(xfer_req), .bf_clr(bf_clr),
        .busy(busy_b), .bus_free(free_b), .qual_done(done_b),
        .xfer_grant(grant_b), .qual_timeout(tmo_b));

    // monitor: compares queued expectations away from the active edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            exp_t e;
            logic [4:0] obs;
            e = sb.pop_front();
            obs = e.byp ? {busy_b, free_b, done_b, grant_b, tmo_b}
                        : {busy, bus_free, qual_done, xfer_grant, qual_timeout};
            n_chk++;
            if ((obs & e.mask) !== (e.exp & e.mask)) begin
                n_err++;
                $display("FAIL %s: got %b expected %b (mask %b)", e.tag, obs, e.exp, e.mask);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_out(string tag, bit byp, logic [4:0] mask, logic [4:0] exp);
        exp_t e;
        e.tag = tag; e.byp = byp; e.mask = mask; e.exp = exp;
        sb.push_back(e);
        wait (sb.size() == 0);
        #1;
    endtask

    task automatic pulse_soft();
        soft_rst = 1'b1; tick(1); soft_rst = 1'b0;
    endtask

    initial begin
        int cyc = 0;
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                n_err++;
                $display("FAIL watchdog: got hung run expected completion");
                $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
                $finish;
            end
        end
    end

    initial begin
        tick(3);
        expect_out("R1 reset outputs low", 0, 5'b11111, 5'b00000);
        rst_n = 1'b1;
        tick(2);
        expect_out("R1 after reset release", 0, 5'b11111, 5'b00000);

        // R2: seed with data low, clock high
        sda = 1'b0; tick(12);
        expect_out("R2 disabled keeps busy low", 0, 5'b10100, 5'b00000);
        xfer_req = 1'b1;
        enable = 1'b1; tick(1);
        expect_out("R2 seed 0/1 gives busy", 0, 5'b10110, 5'b10000);
        expect_out("R12 bypass done one clock after enable", 1, 5'b00100, 5'b00100);
        tick(1);
        expect_out("R7 hold condition ends qualification", 0, 5'b00100, 5'b00100);
        expect_out("R10 no grant while busy", 0, 5'b10010, 5'b10000);

        // R4: STOP
        sda = 1'b1; tick(12);
        expect_out("R4 stop clears busy sets free", 0, 5'b11000, 5'b01000);
        expect_out("R10 grant when done and idle", 0, 5'b00010, 5'b00010);
        xfer_req = 1'b0; tick(1);
        expect_out("R10 no grant without request", 0, 5'b00010, 5'b00000);
        xfer_req = 1'b1;
        tick(20);
        expect_out("R4 free is sticky", 0, 5'b01000, 5'b01000);
        bf_clr = 1'b1; tick(1); bf_clr = 1'b0;
        expect_out("R4 write one clears free", 0, 5'b01000, 5'b00000);

        // R9: clock held low from enable
        scl = 1'b0; tick(12);
        enable = 1'b0; tick(2);
        expect_out("R2 disable clears flags", 0, 5'b11100, 5'b00000);
        enable = 1'b1; tick(1);
        expect_out("R2 seed 1/0 gives idle", 0, 5'b10000, 5'b00000);
        tick(249);
        expect_out("R9 no timeout yet", 0, 5'b00101, 5'b00000);
        tick(70);
        expect_out("R9 timeout raised, no grant", 0, 5'b00111, 5'b00001);

        // R5: tracking continues while failed
        scl = 1'b1; tick(12);
        sda = 1'b0; tick(12);
        expect_out("R5 busy tracked in fail state", 0, 5'b10011, 5'b10001);
        sda = 1'b1; tick(12);
        expect_out("R5 stop tracked in fail state", 0, 5'b11001, 5'b01001);

        // R6 / R8: soft reset with idle lines
        pulse_soft();
        expect_out("R6 soft reset clears done, timeout, free", 0, 5'b11101, 5'b00000);
        tick(28);
        expect_out("R8 window not yet complete", 0, 5'b00100, 5'b00000);
        tick(20);
        expect_out("R8 idle window completes", 0, 5'b00110, 5'b00110);

        // R8: restart of the window by a clock low
        pulse_soft();
        tick(20);
        scl = 1'b0; tick(8);
        scl = 1'b1; tick(35);
        expect_out("R8 low level restarted window", 0, 5'b00101, 5'b00000);
        tick(25);
        expect_out("R8 done after fresh window", 0, 5'b00101, 5'b00100);

        // R6: reseed with busy bus
        sda = 1'b0; tick(12);
        pulse_soft();
        expect_out("R6 soft reset reseeds busy", 0, 5'b10100, 5'b10000);
        tick(1);
        expect_out("R7 event after soft reset ends qualification", 0, 5'b00100, 5'b00100);
        sda = 1'b1; tick(12);
        bf_clr = 1'b1; tick(1); bf_clr = 1'b0;

        // R11: glitch rejection
        sda = 1'b0; tick(2); sda = 1'b1; tick(12);
        expect_out("R11 short pulse ignored", 0, 5'b11000, 5'b00000);
        sda = 1'b0; tick(12);
        expect_out("R3 START sets busy", 0, 5'b10010, 5'b10000);
        sda = 1'b1; tick(12);
        expect_out("R11 stable stop accepted", 0, 5'b11010, 5'b01010);

        // R12: bypass after soft reset while the failing case would qualify
        pulse_soft();
        expect_out("R12 bypass done after soft reset", 1, 5'b00101, 5'b00100);

        finished = 1'b1;
        tick(2);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule